// File: doc/BRIEF.md
# Configuration Port Register Bridge

This block connects a processor's memory-mapped register space to the 16-bit dynamic reconfiguration port of a clock-synthesis primitive. Software never drives the port signals directly. It writes one command word that carries a launch flag, a read flag, a 7-bit port address and 16 bits of write data. It then polls a status word until the busy flag drops. After a read, the low half of the same status word holds the value returned by the primitive.

Two small control registers sit beside the command path. The first holds a core-enable bit and a primitive-enable bit. The second holds a clock-source select code that reads back as written. Masked updates are left to software, which issues a port read and then a port write. The bridge carries out only plain single reads and single writes.

Top module: `drp_bridge`

## Requirements
- R1: After the asynchronous active-low reset, every output is zero, and every register offset reads zero, including the busy flag and the captured read data.
- R2: Offset 0x40 holds two bits. Bit 0 drives `core_en_o` and bit 1 drives `prim_en_o`. A read returns these two bits and zero in every other bit.
- R3: Offset 0x44 holds a SEL_W-bit (default 2) source code, taken from the low bits of the written word. It drives `clk_sel_o` and reads back zero-extended.
- R4: A write to offset 0x70 with bit 29 set, made while not busy, launches a transaction. In the cycle after the write, `drp_en_o` is high for exactly one cycle. In that cycle `drp_addr_o` equals command bits 22:16 and `drp_di_o` equals bits 15:0. `drp_we_o` is high in that cycle only when command bit 28 is 0 (a write); bit 28 set to 1 marks a read.
- R5: Status bit 16 (busy) at offset 0x74 rises in the cycle after an accepted command. It stays high until `drp_rdy_i` is sampled high and falls in the following cycle.
- R6: Status bits 15:0 take `drp_do_i` only on the ready cycle of a read. They hold that value until the next read completes, and are not changed by write completions or by `drp_do_i` at other times.
- R7: A command written while busy is ignored: no enable pulse follows and the port address and data outputs keep their values. A command written with bit 29 clear also starts nothing.
- R8: `drp_rdy_i` while not busy is ignored. Busy stays low and the status data does not change.
- R9: Offset 0x70 and any offset outside 0x40, 0x44 and 0x74 read as zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Single-beat register write strobe |
| reg_addr_i | input | 8 | Byte offset for write and read |
| reg_wdata_i | input | 32 | Write data |
| reg_rdata_o | output | 32 | Read data for `reg_addr_i` (combinational) |
| core_en_o | output | 1 | Core enable, control bit 0 |
| prim_en_o | output | 1 | Primitive enable, control bit 1 |
| clk_sel_o | output | SEL_W | Clock-source select code |
| drp_en_o | output | 1 | Port enable pulse |
| drp_we_o | output | 1 | Port write enable |
| drp_addr_o | output | DADDR_W | Port register address |
| drp_di_o | output | DATA_W | Port write data |
| drp_rdy_i | input | 1 | Port ready |
| drp_do_i | input | DATA_W | Port read data |

## Verification
On every cycle, assertions check the following. The enable pulse lasts one cycle, and write-enable never appears without it. Busy rises only together with a launch and falls one cycle after ready. While busy, no new launch occurs and the address does not move. The captured read data and the select code hold unless their own update condition is met. Other properties depend on the contents of transactions, and only the bench scenarios can show them. These include the exact field slicing of the command word, the returned value of a read after a varying responder latency, a write completion leaving the earlier read value in place, and a stray ready while idle leaving the status untouched. A behavioural model compares every output and the selected read word on every cycle.

// File: rtl/drp_bridge_pkg.sv
package drp_bridge_pkg;
  localparam int unsigned REG_AW = 8;
  localparam logic [REG_AW-1:0] OFF_CTRL = 8'h40;
  localparam logic [REG_AW-1:0] OFF_SRC  = 8'h44;
  localparam logic [REG_AW-1:0] OFF_CMD  = 8'h70;
  localparam logic [REG_AW-1:0] OFF_STAT = 8'h74;
  localparam int unsigned CMD_GO_BIT   = 29;
  localparam int unsigned CMD_RD_BIT   = 28;
  localparam int unsigned CMD_ADDR_LSB = 16;
  localparam int unsigned STAT_BUSY_BIT = 16;

  typedef enum logic [2:0] {
    RSEL_NONE, RSEL_CTRL, RSEL_SRC, RSEL_CMD, RSEL_STAT
  } rsel_e;

  function automatic rsel_e decode(input logic [REG_AW-1:0] a);
    case (a)
      OFF_CTRL: return RSEL_CTRL;
      OFF_SRC:  return RSEL_SRC;
      OFF_CMD:  return RSEL_CMD;
      OFF_STAT: return RSEL_STAT;
      default:  return RSEL_NONE;
    endcase
  endfunction
endpackage

// File: rtl/drp_bridge_cfg.sv
module drp_bridge_cfg #(
  parameter int unsigned SEL_W = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             ctrl_we_i,
  input  logic             src_we_i,
  input  logic [31:0]      wdata_i,
  output logic [1:0]       ctrl_o,
  output logic [SEL_W-1:0] src_o
);
  logic [1:0]       ctrl_q;
  logic [SEL_W-1:0] src_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      src_q  <= '0;
    end else begin
      if (ctrl_we_i) ctrl_q <= wdata_i[1:0];
      if (src_we_i)  src_q  <= wdata_i[SEL_W-1:0];
    end
  end

  assign ctrl_o = ctrl_q;
  assign src_o  = src_q;

  p_src_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !src_we_i |=> $stable(src_q));
  p_ctrl_hold_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_we_i |=> $stable(ctrl_q));
endmodule

// File: rtl/drp_bridge_engine.sv
module drp_bridge_engine
  import drp_bridge_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned DADDR_W = 7
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               cmd_we_i,
  input  logic [31:0]        cmd_i,
  output logic               drp_en_o,
  output logic               drp_we_o,
  output logic [DADDR_W-1:0] drp_addr_o,
  output logic [DATA_W-1:0]  drp_di_o,
  input  logic               drp_rdy_i,
  input  logic [DATA_W-1:0]  drp_do_i,
  output logic               busy_o,
  output logic [DATA_W-1:0]  rd_data_o
);
  localparam int unsigned ADDR_MSB = CMD_ADDR_LSB + DADDR_W - 1;

  logic               busy_q, rd_q, en_q, we_q;
  logic [DADDR_W-1:0] addr_q;
  logic [DATA_W-1:0]  di_q, rd_data_q;
  logic               launch, done;

  assign launch = cmd_we_i & cmd_i[CMD_GO_BIT] & ~busy_q;
  assign done   = busy_q & drp_rdy_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q    <= 1'b0;
      rd_q      <= 1'b0;
      en_q      <= 1'b0;
      we_q      <= 1'b0;
      addr_q    <= '0;
      di_q      <= '0;
      rd_data_q <= '0;
    end else begin
      en_q <= launch;
      we_q <= launch & ~cmd_i[CMD_RD_BIT];
      if (launch) begin
        busy_q <= 1'b1;
        rd_q   <= cmd_i[CMD_RD_BIT];
        addr_q <= cmd_i[ADDR_MSB:CMD_ADDR_LSB];
        di_q   <= cmd_i[DATA_W-1:0];
      end else if (done) begin
        busy_q <= 1'b0;
      end
      if (done && rd_q) rd_data_q <= drp_do_i;
    end
  end

  assign drp_en_o   = en_q;
  assign drp_we_o   = we_q;
  assign drp_addr_o = addr_q;
  assign drp_di_o   = di_q;
  assign busy_o     = busy_q;
  assign rd_data_o  = rd_data_q;

  p_en_pulse_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drp_en_o |=> !drp_en_o);
  p_we_needs_en_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    drp_we_o |-> drp_en_o);
  p_busy_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> drp_en_o);
  p_busy_fall_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && drp_rdy_i |=> !busy_q);
  p_busy_hold_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q && !drp_rdy_i |=> busy_q);
  p_rdata_hold_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(busy_q && drp_rdy_i && rd_q) |=> $stable(rd_data_q));
  p_no_launch_busy_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> !drp_en_o);
  p_addr_stable_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |=> $stable(drp_addr_o));
  p_idle_stays_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !busy_q && !cmd_we_i |=> !busy_q);
endmodule

// File: rtl/drp_bridge.sv
module drp_bridge
  import drp_bridge_pkg::*;
#(
  parameter int unsigned DATA_W  = 16,
  parameter int unsigned DADDR_W = 7,
  parameter int unsigned SEL_W   = 2
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic               reg_wr_i,
  input  logic [7:0]         reg_addr_i,
  input  logic [31:0]        reg_wdata_i,
  output logic [31:0]        reg_rdata_o,
  output logic               core_en_o,
  output logic               prim_en_o,
  output logic [SEL_W-1:0]   clk_sel_o,
  output logic               drp_en_o,
  output logic               drp_we_o,
  output logic [DADDR_W-1:0] drp_addr_o,
  output logic [DATA_W-1:0]  drp_di_o,
  input  logic               drp_rdy_i,
  input  logic [DATA_W-1:0]  drp_do_i
);
  rsel_e              rsel;
  logic [1:0]         ctrl;
  logic               busy;
  logic [DATA_W-1:0]  rd_data;

  assign rsel = decode(reg_addr_i);

  drp_bridge_cfg #(.SEL_W(SEL_W)) u_cfg (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .ctrl_we_i (reg_wr_i && rsel == RSEL_CTRL),
    .src_we_i  (reg_wr_i && rsel == RSEL_SRC),
    .wdata_i   (reg_wdata_i),
    .ctrl_o    (ctrl),
    .src_o     (clk_sel_o)
  );

  drp_bridge_engine #(.DATA_W(DATA_W), .DADDR_W(DADDR_W)) u_eng (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .cmd_we_i   (reg_wr_i && rsel == RSEL_CMD),
    .cmd_i      (reg_wdata_i),
    .drp_en_o   (drp_en_o),
    .drp_we_o   (drp_we_o),
    .drp_addr_o (drp_addr_o),
    .drp_di_o   (drp_di_o),
    .drp_rdy_i  (drp_rdy_i),
    .drp_do_i   (drp_do_i),
    .busy_o     (busy),
    .rd_data_o  (rd_data)
  );

  assign core_en_o = ctrl[0];
  assign prim_en_o = ctrl[1];

  always_comb begin
    reg_rdata_o = '0;
    case (rsel)
      RSEL_CTRL: reg_rdata_o[1:0] = ctrl;
      RSEL_SRC:  reg_rdata_o[SEL_W-1:0] = clk_sel_o;
      RSEL_STAT: begin
        reg_rdata_o[STAT_BUSY_BIT] = busy;
        reg_rdata_o[DATA_W-1:0]    = rd_data;
      end
      default: reg_rdata_o = '0;
    endcase
  end

  p_cmd_reads_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rsel == RSEL_CMD |-> reg_rdata_o == 32'h0);
endmodule

// File: tb/drp_bridge_test.sv
`timescale 1ns/1ps
module drp_bridge_test;
  logic        clk = 1'b0;
  logic        rst_ni = 1'b0;
  logic        reg_wr = 1'b0;
  logic [7:0]  reg_addr = 8'h00;
  logic [31:0] reg_wdata = 32'h0;
  logic [31:0] reg_rdata;
  logic        core_en, prim_en;
  logic [1:0]  clk_sel;
  logic        drp_en, drp_we;
  logic [6:0]  drp_addr;
  logic [15:0] drp_di;
  logic        drp_rdy = 1'b0;
  logic [15:0] drp_do = 16'h0;

  always #4 clk = ~clk;

  drp_bridge uut (
    .clk_i(clk), .rst_ni(rst_ni), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .core_en_o(core_en),
    .prim_en_o(prim_en), .clk_sel_o(clk_sel), .drp_en_o(drp_en),
    .drp_we_o(drp_we), .drp_addr_o(drp_addr), .drp_di_o(drp_di),
    .drp_rdy_i(drp_rdy), .drp_do_i(drp_do)
  );

  int vectors = 0;
  int fails = 0;
  int en_seen = 0;
  bit compare_on = 0;

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    vectors++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h t=%0t", tag, act, exp, $time);
    end
  endtask

  // responder with programmable latency
  logic [15:0] mem [128];
  int lat = 1;
  bit spur = 0;
  bit pend = 0;
  int cnt = 0;
  logic [6:0] r_addr;
  bit r_wr;
  int noise = 0;
  initial for (int i = 0; i < 128; i++) mem[i] = 16'h0;

  always begin
    @(negedge clk);
    #1;
    noise++;
    drp_rdy = spur;
    drp_do = 16'hA5A5 ^ noise[15:0];
    if (!rst_ni) pend = 0;
    else if (drp_en) begin
      pend = 1; cnt = lat; r_addr = drp_addr; r_wr = drp_we;
      if (drp_we) mem[drp_addr] = drp_di;
    end else if (pend) begin
      cnt--;
      if (cnt == 0) begin
        drp_rdy = 1'b1;
        drp_do = r_wr ? 16'hFFFF : mem[r_addr];
        pend = 0;
      end
    end
  end

  // behavioural reference
  bit m_busy, m_en, m_we, m_rdop, m_core, m_prim;
  logic [6:0]  m_addr;
  logic [15:0] m_di, m_rd;
  logic [1:0]  m_sel;

  always @(posedge clk or negedge rst_ni) begin
    if (!rst_ni) begin
      m_busy = 0; m_en = 0; m_we = 0; m_rdop = 0; m_core = 0; m_prim = 0;
      m_addr = 0; m_di = 0; m_rd = 0; m_sel = 0;
    end else begin
      bit was_busy;
      was_busy = m_busy;
      m_en = 0; m_we = 0;
      if (was_busy && drp_rdy) begin
        m_busy = 0;
        if (m_rdop) m_rd = drp_do;
      end
      if (reg_wr) begin
        if (reg_addr == 8'h40) begin m_core = reg_wdata[0]; m_prim = reg_wdata[1]; end
        if (reg_addr == 8'h44) m_sel = reg_wdata[1:0];
        if (reg_addr == 8'h70 && reg_wdata[29] && !was_busy) begin
          m_busy = 1; m_en = 1; m_we = !reg_wdata[28]; m_rdop = reg_wdata[28];
          m_addr = reg_wdata[22:16]; m_di = reg_wdata[15:0];
        end
      end
    end
  end

  function automatic logic [31:0] exp_read(logic [7:0] a);
    case (a)
      8'h40: return {30'h0, m_prim, m_core};
      8'h44: return {30'h0, m_sel};
      8'h74: return {15'h0, m_busy, m_rd};
      default: return 32'h0;
    endcase
  endfunction

  always @(negedge clk) begin
    if (drp_en) en_seen++;
    if (compare_on) begin
      check("R4 drp_en_o", drp_en, m_en);
      check("R4 drp_we_o", drp_we, m_we);
      check("R4 drp_addr_o", drp_addr, m_addr);
      check("R4 drp_di_o", drp_di, m_di);
      check("R2 core_en_o", core_en, m_core);
      check("R2 prim_en_o", prim_en, m_prim);
      check("R3 clk_sel_o", clk_sel, m_sel);
      case (reg_addr)
        8'h40: check("R2 read", reg_rdata, exp_read(reg_addr));
        8'h44: check("R3 read", reg_rdata, exp_read(reg_addr));
        8'h74: check("R5 R6 status", reg_rdata, exp_read(reg_addr));
        default: check("R9 read", reg_rdata, exp_read(reg_addr));
      endcase
    end
  end

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk); #2;
    reg_wr = 1; reg_addr = a; reg_wdata = d;
    @(negedge clk); #2;
    reg_wr = 0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk); #2;
    reg_addr = a;
    @(negedge clk); #1;
    d = reg_rdata;
  endtask

  task automatic wait_idle();
    logic [31:0] s;
    for (int k = 0; k < 100; k++) begin
      rd(8'h74, s);
      if (!s[16]) break;
    end
  endtask

  function automatic logic [31:0] cmd(bit go, bit rdop, logic [6:0] a, logic [15:0] d);
    return {2'b00, go, rdop, 5'h0, a, d};
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL R5 watchdog act=running exp=finished");
    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end

  initial begin
    logic [31:0] v;
    int e0;
    repeat (3) @(negedge clk);
    #2 rst_ni = 1;
    compare_on = 1;
    // R1 reset state
    @(negedge clk); #1;
    check("R1 drp_en_o", drp_en, 0);
    check("R1 drp_addr_o", drp_addr, 0);
    check("R1 clk_sel_o", clk_sel, 0);
    check("R1 core_en_o", core_en, 0);
    rd(8'h74, v); check("R1 status", v, 0);
    rd(8'h40, v); check("R1 ctrl", v, 0);

    // R2 control bits
    wr(8'h40, 32'hFFFF_FFFF);
    rd(8'h40, v); check("R2 ctrl read", v, 32'h3);
    wr(8'h40, 32'h1);
    rd(8'h40, v); check("R2 ctrl core only", v, 32'h1);

    // R3 source select
    wr(8'h44, 32'hFFFF_FFF6);
    rd(8'h44, v); check("R3 sel read", v, 32'h2);

    // R4 write command, R5 busy
    lat = 3;
    wr(8'h70, cmd(1, 0, 7'h15, 16'h1234));
    rd(8'h74, v); check("R5 busy set", v[16], 1);
    wait_idle();
    check("R4 mem written", mem[7'h15], 16'h1234);

    // R6 read back
    wr(8'h70, cmd(1, 1, 7'h15, 16'h0));
    wait_idle();
    rd(8'h74, v); check("R6 read data", v, 32'h0000_1234);

    // R7 command while busy ignored
    lat = 8;
    e0 = en_seen;
    wr(8'h70, cmd(1, 1, 7'h15, 16'h0));
    wr(8'h70, cmd(1, 0, 7'h3A, 16'hBEEF));
    check("R7 addr unchanged", drp_addr, 7'h15);
    wait_idle();
    check("R7 one pulse", en_seen - e0, 1);
    check("R7 mem untouched", mem[7'h3A], 16'h0);

    // R7 go bit clear
    e0 = en_seen;
    wr(8'h70, cmd(0, 0, 7'h3A, 16'hBEEF));
    repeat (3) @(negedge clk);
    check("R7 no launch", en_seen - e0, 0);
    rd(8'h74, v); check("R7 idle", v[16], 0);

    // R8 stray ready
    @(negedge clk); #2 spur = 1;
    @(negedge clk); #2 spur = 0;
    rd(8'h74, v); check("R8 status untouched", v, 32'h0000_1234);

    // R6 write completion keeps read data
    lat = 2;
    wr(8'h70, cmd(1, 0, 7'h40, 16'h5555));
    wait_idle();
    rd(8'h74, v); check("R6 held after write", v, 32'h0000_1234);

    // R9 zero reads
    rd(8'h70, v); check("R9 cmd reads zero", v, 0);
    rd(8'h48, v); check("R9 unmapped", v, 0);

    // sweep latencies and addresses
    for (int i = 0; i < 8; i++) begin
      lat = 1 + (i % 4);
      wr(8'h70, cmd(1, 0, 7'(i * 13 + 1), 16'(16'h9000 + i * 257)));
      wait_idle();
      wr(8'h70, cmd(1, 1, 7'(i * 13 + 1), 16'h0));
      wait_idle();
      rd(8'h74, v); check("R6 sweep read", v, {16'h0, 16'(16'h9000 + i * 257)});
    end

    // R1 reset mid-transaction
    lat = 6;
    wr(8'h70, cmd(1, 1, 7'h01, 16'h0));
    @(negedge clk); #2 rst_ni = 0; compare_on = 0;
    @(negedge clk); #2 rst_ni = 1; compare_on = 1;
    rd(8'h74, v); check("R1 reset clears status", v, 0);
    repeat (10) @(negedge clk);

    $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
    $finish;
  end
endmodule